// File: doc/BRIEF.md
# Shared-Line Interrupt Mux for Multi-UART Slots

The block sits between a byte-wide host I/O bus and a row of UART slots (four by default, eight when `NCH` is 8) that share one host interrupt line. It decodes an address window of eight bytes per slot starting at `BASE`. For each access in that window it raises the chip select of the addressed slot and passes the low three address bits through as the local register offset. Host reads are returned one cycle later together with a valid flag.

Byte 7 of slot 0 belongs to the mux and never reaches UART 0. A write to that byte loads a per-channel interrupt enable mask. A read from it returns a pending byte. Bit n of the pending byte is UART n's interrupt input gated by enable bit n. When fewer than eight channels are built, the unused upper bits read as ones.

The OR of the pending bits drives a two-state machine. `IRQ_IDLE` moves to `IRQ_RAISED` (transition *raise*) when any pending bit is set. `IRQ_RAISED` returns to `IRQ_IDLE` (transition *clear*) when none is set. Each state otherwise holds. The registered state is the host interrupt, so the host sees a clean rising edge. The enable mask has no reset and powers up arbitrary, so software writes it before relying on the interrupt.

Top module: `uart_irq_mux`

## Requirements
- R1: An access at window address `BASE + 8*n + k` (k from 0 to 7, excluding n=0 with k=7) asserts only `slot_cs[n]`, with `slot_off` = k, in the same cycle as the strobe.
- R2: An access at `BASE + 7` asserts no chip select.
- R3: A write at `BASE + 7` loads enable bit n from write-data bit n. No other address changes the mask. Byte 7 of any other slot is passed through to that slot.
- R4: A read at `BASE + 7` returns, in the cycle after the strobe with `bus_rvalid` high, bit n = `uart_irq[n]` AND enable bit n. Bits 7 down to `NCH` read as 1.
- R5: A read at any other window address returns the addressed slot's `slot_rdata` byte, sampled at the strobe, in the following cycle with `bus_rvalid` high.
- R6: An access outside the window asserts no chip select. `bus_rvalid` stays low in the next cycle and `bus_rdata` reads 0.
- R7: `host_irq` goes high one cycle after any pending bit is set (*raise*). It goes low one cycle after all pending bits are clear (*clear*).
- R8: During and straight after reset, `host_irq`, `bus_rvalid` and all chip selects are low.
- R9: An event that arrives while another channel is pending shows in the pending byte, and `host_irq` stays high until every pending bit is clear.
- R10: An interrupt input whose enable bit is 0 neither sets its pending bit nor raises `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Host byte address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` holds a window read |
| slot_cs | output | NCH | One chip select per UART slot |
| slot_off | output | 3 | Local register offset inside the slot |
| slot_rd | output | 1 | Read strobe toward the selected slot |
| slot_wr | output | 1 | Write strobe toward the selected slot |
| slot_wdata | output | 8 | Write data toward the slots |
| slot_rdata | input | 8*NCH | Read data of each slot, slot n in bits 8n+7..8n |
| uart_irq | input | NCH | Interrupt request of each UART |
| host_irq | output | 1 | Combined host interrupt |

## Verification
Chip selects, offset and slot strobes are combinational, so the bench checks them 1 ns after it drives the strobe at a falling edge. Read data and `bus_rvalid` are due one clock later. The driver pushes the expected byte into a queue when it issues the read, and a monitor pops and compares it at the next falling edge on which `bus_rvalid` is high. `host_irq` trails a change on `uart_irq` or the mask by exactly one rising edge, so the bench samples it at the falling edge after that edge.

// File: rtl/uim_pkg.sv
package uim_pkg;
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int SLOT_BYTES = 8;
    localparam int CTL_OFFSET = 7;
endpackage

// File: rtl/uim_decode.sv
module uim_decode
    import uim_pkg::*;
#(
    parameter int AW   = 16,
    parameter int BASE = 'h200,
    parameter int NCH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd,
    input  logic              wr,
    output logic              in_win,
    output logic              ctl_hit,
    output logic [$clog2(NCH)-1:0] slot_idx,
    output logic [2:0]        off,
    output logic [NCH-1:0]    cs
);
    localparam int WIN = SLOT_BYTES * NCH;
    localparam int SW  = $clog2(NCH);

    logic [AW-1:0] rel;

    always_comb begin
        rel      = addr - AW'(BASE);
        in_win   = (addr >= AW'(BASE)) && (rel < AW'(WIN));
        ctl_hit  = in_win && (rel == AW'(CTL_OFFSET));
        slot_idx = rel[SW+2:3];
        off      = rel[2:0];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_cs
        assign cs[n] = (rd || wr) && in_win && !ctl_hit && (slot_idx == SW'(n));
    end

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));
    // R2
    ctl_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd || wr) && ctl_hit) |-> (cs == '0));
    // R6
    miss_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (cs == '0));
endmodule

// File: rtl/uim_chan_ctl.sv
module uim_chan_ctl #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [NCH-1:0] ld_val,
    input  logic [NCH-1:0] irq_in,
    output logic [NCH-1:0] pending,
    output logic [7:0]     status
);
    logic [NCH-1:0] mask_q;

    // enable mask deliberately carries no reset
    always_ff @(posedge clk) begin
        if (ld) begin
            mask_q <= ld_val;
        end
    end

    assign pending = irq_in & mask_q;

    if (NCH < 8) begin : g_pad
        assign status = {{(8-NCH){1'b1}}, pending};
    end else begin : g_full
        assign status = pending;
    end

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (pending == (irq_in & $past(ld_val))));
    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & ~irq_in) == '0));
endmodule

// File: rtl/uim_irq_fsm.sv
module uim_irq_fsm
    import uim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic host_irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_pending) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        host_irq = (state_q == IRQ_RAISED);
    end

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pending |=> host_irq);
    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pending |=> !host_irq);
endmodule

// File: rtl/uart_irq_mux.sv
module uart_irq_mux #(
    parameter int AW   = 16,
    parameter int BASE = 'h200,
    parameter int NCH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             bus_rvalid,
    output logic [NCH-1:0]   slot_cs,
    output logic [2:0]       slot_off,
    output logic             slot_rd,
    output logic             slot_wr,
    output logic [7:0]       slot_wdata,
    input  logic [8*NCH-1:0] slot_rdata,
    input  logic [NCH-1:0]   uart_irq,
    output logic             host_irq
);
    localparam int SW = $clog2(NCH);

    logic          in_win, ctl_hit;
    logic [SW-1:0] slot_idx;
    logic [NCH-1:0] pending;
    logic [7:0]    status;
    logic [7:0]    rdata_q;
    logic          rvalid_q;

    uim_decode #(.AW(AW), .BASE(BASE), .NCH(NCH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .in_win   (in_win),
        .ctl_hit  (ctl_hit),
        .slot_idx (slot_idx),
        .off      (slot_off),
        .cs       (slot_cs)
    );

    uim_chan_ctl #(.NCH(NCH)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (bus_wr && ctl_hit),
        .ld_val  (bus_wdata[NCH-1:0]),
        .irq_in  (uart_irq),
        .pending (pending),
        .status  (status)
    );

    uim_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_pending (|pending),
        .host_irq    (host_irq)
    );

    assign slot_rd    = bus_rd && in_win && !ctl_hit;
    assign slot_wr    = bus_wr && in_win && !ctl_hit;
    assign slot_wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd && in_win;
            if (bus_rd && in_win) begin
                rdata_q <= ctl_hit ? status : slot_rdata[{slot_idx, 3'b000} +: 8];
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    // R5
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd && in_win));
    // R6
    miss_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_win) |=> (!bus_rvalid && bus_rdata == 8'h00));
    // R4
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ctl_hit) |=> (bus_rvalid && bus_rdata == $past(status)));
endmodule

// File: tb/sim_uart_irq_mux.sv
module sim_uart_irq_mux;
    localparam int AW   = 16;
    localparam int BASE = 'h200;
    localparam int NCH  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic             bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             bus_rvalid;
    logic [NCH-1:0]   slot_cs;
    logic [2:0]       slot_off;
    logic             slot_rd, slot_wr;
    logic [7:0]       slot_wdata;
    logic [8*NCH-1:0] slot_rdata;
    logic [NCH-1:0]   uart_irq = '0;
    logic             host_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    // register stubs: slot n returns 16*(n+1) + offset
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            slot_rdata[8*n +: 8] = 8'(16 * (n + 1)) + {5'd0, slot_off};
        end
    end

    uart_irq_mux #(.AW(AW), .BASE(BASE), .NCH(NCH)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected rvalid", int'(bus_rdata), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(bus_rdata == e, t, int'(bus_rdata), int'(e));
            end
        end
    end

    task automatic access(input bit rd, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic [NCH-1:0] exp_cs, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = !rd; bus_wdata = d;
        #1;
        check(slot_cs == exp_cs, req, int'(slot_cs), int'(exp_cs));
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] e,
                          input logic [NCH-1:0] exp_cs, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        access(1'b1, a, 8'h00, exp_cs, req);
    endtask

    task automatic set_irq(input logic [NCH-1:0] v);
        @(negedge clk);
        uart_irq = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8
        check(host_irq == 1'b0 && bus_rvalid == 1'b0 && slot_cs == '0, "R8 in reset",
              int'({host_irq, bus_rvalid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_irq == 1'b0 && bus_rvalid == 1'b0, "R8 after reset",
              int'({host_irq, bus_rvalid}), 0);

        // R2 R3: load mask, no chip select
        access(1'b0, AW'(BASE + 7), 8'h0F, '0, "R2 mask write cs");
        rd_exp(AW'(BASE + 7), 8'hF0, '0, "R4 idle status");

        // R7 raise
        set_irq(4'b0100);
        check(host_irq == 1'b1, "R7 raise", int'(host_irq), 1);
        rd_exp(AW'(BASE + 7), 8'hF4, '0, "R4 one pending");

        // R9 new event during service
        set_irq(4'b0110);
        rd_exp(AW'(BASE + 7), 8'hF6, '0, "R9 second event visible");
        set_irq(4'b0010);
        check(host_irq == 1'b1, "R9 line stays high", int'(host_irq), 1);
        rd_exp(AW'(BASE + 7), 8'hF2, '0, "R9 remaining event");
        set_irq(4'b0000);
        check(host_irq == 1'b0, "R7 clear", int'(host_irq), 0);

        // R10 masked channels
        access(1'b0, AW'(BASE + 7), 8'h05, '0, "R3 mask write 05");
        set_irq(4'b1010);
        check(host_irq == 1'b0, "R10 masked no irq", int'(host_irq), 0);
        rd_exp(AW'(BASE + 7), 8'hF0, '0, "R10 masked status");
        set_irq(4'b1011);
        check(host_irq == 1'b1, "R10 enabled raises", int'(host_irq), 1);
        rd_exp(AW'(BASE + 7), 8'hF1, '0, "R4 enabled bit");

        // R3: byte 7 of slot 1 goes to the slot, mask unchanged
        access(1'b0, AW'(BASE + 15), 8'h00, 4'b0010, "R3 slot1 scratch passthrough");
        rd_exp(AW'(BASE + 7), 8'hF1, '0, "R3 mask kept");
        set_irq(4'b0000);

        // R1 R5 passthrough
        for (int n = 0; n < NCH; n++) begin
            for (int k = 0; k < 8; k += 3) begin
                automatic int kk = (k == 6) ? 7 : k;
                if (!(n == 0 && kk == 7)) begin
                    rd_exp(AW'(BASE + 8*n + kk), 8'(16*(n+1) + kk), 4'(1 << n),
                           "R1 R5 slot read");
                end
            end
        end
        @(negedge clk);
        bus_addr = AW'(BASE + 8*2 + 5); bus_wr = 1'b1; bus_wdata = 8'h3C;
        #1;
        check(slot_cs == 4'b0100 && slot_off == 3'd5 && slot_wr && slot_wdata == 8'h3C,
              "R1 write passthrough", int'({slot_cs, slot_off}), int'({4'b0100, 3'd5}));
        @(negedge clk);
        bus_wr = 1'b0;

        // R6 outside the window
        access(1'b1, AW'(BASE - 1), 8'h00, '0, "R6 below window");
        check(bus_rvalid == 1'b0 && bus_rdata == 8'h00, "R6 no rvalid below",
              int'(bus_rvalid), 0);
        access(1'b1, AW'(BASE + 8*NCH), 8'h00, '0, "R6 above window");
        check(bus_rvalid == 1'b0 && bus_rdata == 8'h00, "R6 no rvalid above",
              int'(bus_rvalid), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 missing read results", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule